// File: doc/BRIEF.md
# UART Receive Character Time-Out Detector

This block watches the receive side of a UART that runs with a receive FIFO. When characters are waiting in the FIFO and no new character has arrived for a span that depends on the programmed data word length, it raises a time-out flag. The interrupt logic uses that flag to tell software to drain a partly filled FIFO that has not reached its trigger level.

Idle time is measured in ticks of the 16x oversampling baud clock, and one bit time is 16 ticks. The span is (4 x P + 12) bit times, where P is the data word length of 5 to 8 bits, so the span runs from 32 to 44 bit times. The count starts again at the centre of every received stop bit and after every CPU read of the FIFO. The count is held at zero while the FIFO is empty or FIFO mode is off. Once the flag is set, it stays set until software reads the FIFO, a new stop bit arrives, the FIFO empties or FIFO mode is turned off.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `timeout_o` is 0 and the idle count is zero.
- R2: `word_len_i` encodes the word length P as 00=5, 01=6, 10=7 and 11=8 bits. `timeout_o` rises at the clock edge that accepts the (4P+12)x16-th counted `tick16_i` pulse: 512, 576, 640 or 704 ticks. It is still 0 after one tick fewer.
- R3: While `fifo_nonempty_i` is 0, no ticks are counted and `timeout_o` stays 0. Counting starts afresh from zero once the FIFO holds data again.
- R4: While `fifo_en_i` is 0, no ticks are counted and `timeout_o` stays 0. Turning `fifo_en_i` off clears a set flag on the next edge.
- R5: A `stop_mid_i` pulse restarts the count from zero.
- R6: A `fifo_rd_i` pulse restarts the count from zero and clears a set flag on the next edge.
- R7: A set `timeout_o` stays 1 through any number of further ticks while no clearing event occurs.
- R8: A `stop_mid_i` pulse clears a set flag on the next edge.
- R9: `fifo_nonempty_i` going to 0 clears a set flag and the count on the next edge.
- R10: A tick that arrives in the same cycle as a restart event is not counted.
- R11: Clock cycles without `tick16_i` do not advance the count, however many there are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16_i | input | 1 | One-cycle pulse at 16x the baud rate |
| word_len_i | input | 2 | Data word length code (00=5 to 11=8 bits) |
| fifo_en_i | input | 1 | FIFO mode enable |
| fifo_nonempty_i | input | 1 | Receive FIFO holds at least one character |
| stop_mid_i | input | 1 | Pulse at the centre of a received stop bit |
| fifo_rd_i | input | 1 | Pulse when the CPU reads the receive FIFO |
| timeout_o | output | 1 | Character time-out flag |

## Verification
The main stimulus is a table that steps through all four word-length codes. For each code it gives one tick fewer than the span and then the final tick. This separates a correct 4P+12 slope and offset from an off-by-one span or a fixed span. Directed sequences then do the following:
- They send a full span of ticks with the FIFO empty and with FIFO mode off, so that a detector that ignores either gate is exposed.
- They restart the count just short of the span, with a stop bit and with a restart that lands on the same cycle as a tick. This shows whether the restart truly zeroes the count and takes priority.
- They wait long stretches without ticks, so that a design counting clock cycles instead of ticks is caught.
- They apply each clearing event to a set flag, so that a flag that clears too eagerly or not at all is caught.

// File: rtl/rto_pkg.sv
package rto_pkg;
   // Word-length code carried on word_len_i
   typedef enum logic [1:0] {
      WL_5 = 2'b00,
      WL_6 = 2'b01,
      WL_7 = 2'b10,
      WL_8 = 2'b11
   } wlen_e;

   localparam int unsigned DEF_OVS      = 16; // ticks per bit time
   localparam int unsigned DEF_BASE_LEN = 5;  // word length for code 0
   localparam int unsigned DEF_SLOPE    = 4;  // bit times per data bit
   localparam int unsigned DEF_OFFSET   = 12; // fixed bit times added
endpackage

// File: rtl/rto_span.sv
// Converts the word-length code into a span measured in 16x ticks.
module rto_span #(
   parameter int unsigned LEN_W    = 2,
   parameter int unsigned BASE_LEN = 5,
   parameter int unsigned SLOPE    = 4,
   parameter int unsigned OFFSET   = 12,
   parameter int unsigned OVS      = 16,
   parameter int unsigned CNT_W    = 10
) (
   input  logic [LEN_W-1:0] word_len_i,
   output logic [CNT_W-1:0] limit_o
);
   int unsigned bits_v;

   always_comb begin
      bits_v  = SLOPE * (BASE_LEN + int'(word_len_i)) + OFFSET;
      limit_o = CNT_W'(bits_v * OVS);
   end
endmodule

// File: rtl/rto_tick_counter.sv
// Counts 16x ticks since the last restart; reports the span-closing tick.
module rto_tick_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             clear_i,
   input  logic             hold_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             adv;

   assign adv   = tick_i && !clear_i && !hold_i;
   assign hit_o = adv && (cnt_q >= limit_i - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear_i)
         cnt_q <= '0;
      else if (adv)
         cnt_q <= hit_o ? '0 : cnt_q + CNT_W'(1);
   end

   // R11: no tick, no restart -> count unchanged
   a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clear_i) |=> $stable(cnt_q));
   // R5 / R10: restart leaves the count at zero, tick or not
   a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_q == '0));
   // R2: a counted tick that is not the last one moves the count up by one
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !hit_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/rto_flag_reg.sv
// Sticky time-out flag with its clearing events.
module rto_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic clear_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (clear_i)
         flag_o <= 1'b0;
      else if (hit_i)
         flag_o <= 1'b1;
   end

   // R7: flag is sticky while no clearing event occurs
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clear_i) |=> flag_o);
   // R2: flag only rises on a span-closing tick
   a_r2_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(hit_i));
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
   import rto_pkg::*;
#(
   parameter int unsigned LEN_W    = 2,
   parameter int unsigned OVS      = DEF_OVS,
   parameter int unsigned BASE_LEN = DEF_BASE_LEN,
   parameter int unsigned SLOPE    = DEF_SLOPE,
   parameter int unsigned OFFSET   = DEF_OFFSET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick16_i,
   input  logic [LEN_W-1:0] word_len_i,
   input  logic             fifo_en_i,
   input  logic             fifo_nonempty_i,
   input  logic             stop_mid_i,
   input  logic             fifo_rd_i,
   output logic             timeout_o
);
   localparam int unsigned MAX_LEN  = BASE_LEN + (1 << LEN_W) - 1;
   localparam int unsigned MAX_BITS = SLOPE * MAX_LEN + OFFSET;
   localparam int unsigned CNT_W    = $clog2(MAX_BITS * OVS + 1);

   generate
      if (OVS < 2) begin : g_bad_ovs
         $error("rx_idle_timeout: OVS must be at least 2");
      end
      if (SLOPE == 0 && OFFSET == 0) begin : g_bad_span
         $error("rx_idle_timeout: span would be zero");
      end
      if (LEN_W == 0 || LEN_W > 4) begin : g_bad_lenw
         $error("rx_idle_timeout: LEN_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] limit;
   logic             restart;
   logic             hit;

   // R3 R4 R5 R6 R9: every event that restarts the count also clears the flag
   assign restart = !fifo_en_i || !fifo_nonempty_i || stop_mid_i || fifo_rd_i;

   rto_span #(
      .LEN_W(LEN_W), .BASE_LEN(BASE_LEN), .SLOPE(SLOPE),
      .OFFSET(OFFSET), .OVS(OVS), .CNT_W(CNT_W)
   ) u_span (
      .word_len_i(word_len_i),
      .limit_o   (limit)
   );

   rto_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick16_i),
      .clear_i(restart),
      .hold_i (timeout_o),
      .limit_i(limit),
      .hit_o  (hit)
   );

   rto_flag_reg u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (hit),
      .clear_i(restart),
      .flag_o (timeout_o)
   );

   // R4: FIFO mode off -> flag low next cycle
   a_r4_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en_i |=> !timeout_o);
   // R3 / R9: empty FIFO -> flag low next cycle
   a_r9_empty_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_nonempty_i |=> !timeout_o);
   // R6: CPU read clears the flag
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_i |=> !timeout_o);
   // R8: stop bit clears the flag
   a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop_mid_i |=> !timeout_o);
   // R1: flag low in the cycle after reset
   a_r1_reset_low: assert property (@(posedge clk)
      !rst_n |=> !timeout_o);
endmodule

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 4;
   // word-length code and expected span in bit times
   localparam logic [1:0] VEC_CODE [NVEC] = '{2'b00, 2'b01, 2'b10, 2'b11};
   localparam int         VEC_BITS [NVEC] = '{32, 36, 40, 44};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [1:0] word_len = 2'b10;
   logic       fifo_en = 1'b1;
   logic       nonempty = 1'b1;
   logic       stop_mid = 1'b0;
   logic       fifo_rd = 1'b0;
   logic       timeout;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_idle_timeout u_dut (
      .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .word_len_i(word_len),
      .fifo_en_i(fifo_en), .fifo_nonempty_i(nonempty),
      .stop_mid_i(stop_mid), .fifo_rd_i(fifo_rd), .timeout_o(timeout)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: timeout actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick16 = 1'b1;
         @(negedge clk) tick16 = 1'b0;
      end
   endtask

   task automatic pulse_stop();
      @(negedge clk) stop_mid = 1'b1;
      @(negedge clk) stop_mid = 1'b0;
   endtask

   task automatic pulse_rd();
      @(negedge clk) fifo_rd = 1'b1;
      @(negedge clk) fifo_rd = 1'b0;
   endtask

   localparam int L7 = 40 * 16;

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", timeout, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", timeout, 1'b0);

      // Table walk: R2 span per code, R6 read clears
      for (int i = 0; i < NVEC; i++) begin
         word_len = VEC_CODE[i];
         pulse_stop();
         ticks(VEC_BITS[i] * 16 - 1);
         check("R2 one tick short", timeout, 1'b0);
         ticks(1);
         check("R2 span reached", timeout, 1'b1);
         pulse_rd();
         check("R6 read clears", timeout, 1'b0);
      end

      word_len = 2'b10;
      // R6 read restarts count
      ticks(L7 - 1);
      pulse_rd();
      ticks(L7 - 1);
      check("R6 read restarts", timeout, 1'b0);
      ticks(1);
      check("R6 full span after read", timeout, 1'b1);
      // R7 sticky
      ticks(50);
      repeat (20) @(negedge clk);
      check("R7 sticky", timeout, 1'b1);
      // R8 stop clears
      pulse_stop();
      check("R8 stop clears", timeout, 1'b0);
      // R5 stop restarts
      ticks(L7 - 1);
      pulse_stop();
      ticks(L7 - 1);
      check("R5 stop restarts", timeout, 1'b0);
      ticks(1);
      check("R5 span after stop", timeout, 1'b1);

      // R9 empty clears flag and count
      @(negedge clk) nonempty = 1'b0;
      @(negedge clk) nonempty = 1'b1;
      check("R9 empty clears flag", timeout, 1'b0);
      ticks(L7 - 1);
      check("R9 count cleared", timeout, 1'b0);
      ticks(1);
      check("R9 span after refill", timeout, 1'b1);

      // R3 no counting while empty
      @(negedge clk) nonempty = 1'b0;
      ticks(L7 + 5);
      check("R3 empty no flag", timeout, 1'b0);
      nonempty = 1'b1;
      ticks(L7 - 1);
      check("R3 fresh count", timeout, 1'b0);
      ticks(1);
      check("R3 span after data", timeout, 1'b1);

      // R4 FIFO mode off
      @(negedge clk) fifo_en = 1'b0;
      @(negedge clk);
      check("R4 disable clears", timeout, 1'b0);
      ticks(L7 + 5);
      check("R4 off no flag", timeout, 1'b0);
      fifo_en = 1'b1;
      ticks(L7 - 1);
      check("R4 fresh count", timeout, 1'b0);
      ticks(1);
      check("R4 span after enable", timeout, 1'b1);
      pulse_rd();

      // R10 tick coincident with restart not counted
      ticks(L7 - 1);
      @(negedge clk) begin tick16 = 1'b1; stop_mid = 1'b1; end
      @(negedge clk) begin tick16 = 1'b0; stop_mid = 1'b0; end
      check("R10 coincident restart", timeout, 1'b0);
      ticks(L7 - 1);
      check("R10 tick not counted", timeout, 1'b0);
      ticks(1);
      check("R10 span", timeout, 1'b1);
      pulse_rd();

      // R11 idle cycles without ticks
      ticks(L7 - 1);
      repeat (3000) @(negedge clk);
      check("R11 no tick no advance", timeout, 1'b0);
      ticks(1);
      check("R11 last tick", timeout, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule